// File: doc/BRIEF.md
# Programmable Half-Duty Clock Divider

The block divides its input clock by an integer N that can be changed at run time and keeps the output high for exactly half of every output period, for odd N as well as even N. A counter clocked on the rising edge builds a base divided waveform whose high phase lasts floor(N/2) input cycles. A single register clocked on the falling edge produces a copy of that waveform delayed by half an input period. For odd N the two waveforms are ORed, which adds the missing half cycle to the high phase. For even N the delayed copy is held low, so the base waveform alone forms the output.

The divide value is captured only at the boundary of an output period, so a change never shortens or stretches the period in progress. The odd/even choice for the falling-edge path comes from that captured value. Divide values of 0 and 1 select bypass, and the input clock passes straight to the output. Reset is asynchronous and active low, and its release is synchronised to the rising edge. The output stays low while reset is held.

Top module: `clkdiv50`

## Requirements
- R1: For a captured divide value N from 2 to 255, the output repeats with a period of exactly N input clock periods.
- R2: For every N from 2 to 255, the output is high for N half input periods and low for N half input periods.
- R3: The rising-edge waveform goes high on the edge that starts a count of 0. It falls on the edge where the count reaches floor(N/2). The count runs from 0 to N-1.
- R4: The falling-edge register takes, on each falling input edge, the rising-edge waveform ANDed with the odd flag of the captured N. It therefore presents that waveform delayed by half an input period.
- R5: When the captured N is even, the delayed copy stays low and the output equals the rising-edge waveform.
- R6: A new value on `div_i` is captured only on the rising edge that ends an output period. A change made partway through a period leaves that period unchanged. The next period uses the new value, including its odd/even selection.
- R7: When the captured value is 0 or 1, `clk_o` follows `clk_i`. A new value is then captured on every rising edge.
- R8: While `rst_ni` is low, `clk_o` is low. After release, two rising edges synchronise the reset. The next rising edge starts a complete output period of the value present on `div_i`.
- R9: For a captured N of 2 or more, the counter never reaches or exceeds N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset, release synchronised inside |
| div_i | input | 8 | Divide value N; 0 and 1 select bypass |
| clk_o | output | 1 | Divided clock with half duty cycle |

## Verification
The output can change on either input edge, so every result is read one nanosecond after an input edge and counted in half input periods. The rising-edge waveform and the bypass selection move on the rising edge after a capture. The delayed copy moves on the following falling edge. A new divide value therefore shows its effect only from the first rising edge of the next output period. After each new value the bench waits at least two full old periods plus two new periods before it measures. For the mid-period change, the bench counts the current period and the next period back to back, so that the old and new values are each judged on the period they own. After reset release, sampling starts before the two synchroniser edges. That way the low hold and the first full period are both observed.

// File: rtl/clkdiv50_pkg.sv
package clkdiv50_pkg;
  // width of the divide value and of the period counter
  localparam int unsigned DivW = 8;
  // number of flops in the reset release synchroniser
  localparam int unsigned RstStages = 2;
endpackage

// File: rtl/clkdiv50_rst_sync.sv
module clkdiv50_rst_sync #(
  parameter int unsigned STAGES = clkdiv50_pkg::RstStages
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  localparam int unsigned Top = STAGES - 1;

  logic [Top:0] sync_q;
  logic [Top:0] sync_d;

  // shift a one in from the bottom once reset is released
  always_comb begin
    sync_d = {sync_q[Top-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[Top];
endmodule

// File: rtl/clkdiv50_rise.sv
module clkdiv50_rise #(
  parameter int unsigned W = clkdiv50_pkg::DivW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic         rise_o,
  output logic         odd_o,
  output logic         byp_o
);
  localparam logic [W-1:0] One = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] n_q, n_d;
  logic         r_q, r_d;
  logic         byp_q, byp_d;
  logic         short_q, short_d;
  logic         wrap;
  logic         ld_en;

  // next-state logic
  always_comb begin
    short_q = (n_q[W-1:1] == '0);
    wrap    = short_q || (cnt_q == (n_q - One));
    ld_en   = wrap;
    cnt_d   = wrap ? '0 : (cnt_q + One);
    n_d     = ld_en ? div_i : n_q;
    short_d = (n_d[W-1:1] == '0);
    r_d     = !short_d && (cnt_d < (n_d >> 1));
    byp_d   = short_d;
  end

  // counter and waveform registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      r_q   <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      r_q   <= r_d;
      byp_q <= byp_d;
    end
  end

  // captured divide value, loaded only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
    end else if (ld_en) begin
      n_q <= n_d;
    end
  end

  assign rise_o = r_q;
  assign odd_o  = n_q[0];
  assign byp_o  = byp_q;

  // R9: counter stays below the captured value
  a_r9_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !short_q |-> (cnt_q < n_q));

  // R6: captured value moves only on a wrap
  a_r6_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(n_q));

  // R3: waveform rises only at count zero
  a_r3_rise_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(r_q) |-> (cnt_q == '0));

  // R3: waveform falls at half the captured value
  a_r3_fall_at_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(r_q) |-> (cnt_q == (n_q >> 1)));
endmodule

// File: rtl/clkdiv50_fall.sv
module clkdiv50_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic odd_i,
  output logic late_o
);
  logic late_q, late_d;

  // gate the copy with the captured odd flag
  always_comb begin
    late_d = rise_i & odd_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      late_q <= 1'b0;
    end else begin
      late_q <= late_d;
    end
  end

  assign late_o = late_q;

  // R4: the copy is high only if the base waveform was high half a period before
  a_r4_delayed_copy: assert property (@(negedge clk_i) disable iff (!rst_ni)
    late_q |-> $past(rise_i));

  // R5: an even captured value keeps the copy low
  a_r5_even_quiet: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$past(odd_i) |-> !late_q);
endmodule

// File: rtl/clkdiv50.sv
module clkdiv50 #(
  parameter int unsigned W = clkdiv50_pkg::DivW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic         clk_o
);
  logic rst_sync_n;
  logic rise;
  logic odd;
  logic byp;
  logic late;

  clkdiv50_rst_sync #(
    .STAGES (clkdiv50_pkg::RstStages)
  ) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  clkdiv50_rise #(
    .W (W)
  ) i_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .div_i  (div_i),
    .rise_o (rise),
    .odd_o  (odd),
    .byp_o  (byp)
  );

  clkdiv50_fall i_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .rise_i (rise),
    .odd_i  (odd),
    .late_o (late)
  );

  // combine both edge paths, or pass the clock through in bypass
  always_comb begin
    clk_o = byp ? clk_i : (rise | late);
  end

  // R7: bypass flag never coexists with an active divided waveform
  a_r7_bypass_exclusive: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    byp |-> !rise);
endmodule

// File: tb/test_clkdiv50.sv
`timescale 1ns/1ps
module test_clkdiv50;
  logic       clk_i;
  logic       rst_ni;
  logic [7:0] div_i;
  logic       clk_o;

  int checks;
  int errors;

  localparam int NV = 21;
  localparam int tbl_div [NV] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12,
                                  13, 14, 15, 16, 17, 18, 19, 20, 254, 255};
  localparam int tbl_hi  [NV] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12,
                                  13, 14, 15, 16, 17, 18, 19, 20, 254, 255};

  clkdiv50 i_clkdiv50 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .clk_o  (clk_o)
  );

  initial clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one sample per half input period, 1 ns after each input edge
  task automatic half();
    @(clk_i);
    #1;
  endtask

  task automatic wait_halves(input int n);
    for (int k = 0; k < n; k++) half();
  endtask

  task automatic sync_rise();
    int g;
    g = 0;
    half();
    while (clk_o !== 1'b0 && g < 4000) begin half(); g++; end
    while (clk_o !== 1'b1 && g < 4000) begin half(); g++; end
  endtask

  // counts the current sample and all following samples at level v
  task automatic run(input logic v, output int n);
    n = 0;
    while (clk_o === v && n < 4000) begin n++; half(); end
  endtask

  initial begin
    int hi, lo, hi2, lo2, prev;
    checks = 0;
    errors = 0;
    rst_ni = 1'b0;
    div_i  = 8'd4;
    wait_halves(6);
    // R8: output low while reset is held
    chk(clk_o === 1'b0, "R8 reset low", int'(clk_o), 0);
    rst_ni = 1'b1;
    prev = 4;

    // table walk: period and duty for each divide value
    for (int i = 0; i < NV; i++) begin
      div_i = 8'(tbl_div[i]);
      wait_halves(4 * (prev + tbl_div[i]) + 8);
      sync_rise();
      run(1'b1, hi);
      run(1'b0, lo);
      if (tbl_div[i] % 2 == 1) begin
        chk(hi == tbl_hi[i], "R2/R3/R4 odd high time", hi, tbl_hi[i]);
      end else begin
        chk(hi == tbl_hi[i], "R2/R5 even high time", hi, tbl_hi[i]);
      end
      chk(lo == tbl_hi[i], "R2 low time", lo, tbl_hi[i]);
      chk(hi + lo == 2 * tbl_div[i], "R1 period in half periods", hi + lo, 2 * tbl_div[i]);
      prev = tbl_div[i];
    end

    // R6: change mid-period from even 6 to odd 9
    div_i = 8'd6;
    wait_halves(4 * (prev + 6) + 8);
    sync_rise();
    half();
    div_i = 8'd9;
    run(1'b1, hi);
    hi = hi + 1;
    run(1'b0, lo);
    run(1'b1, hi2);
    run(1'b0, lo2);
    chk(hi == 6, "R6 old period high", hi, 6);
    chk(lo == 6, "R6 old period low", lo, 6);
    chk(hi2 == 9, "R6 new period high", hi2, 9);
    chk(lo2 == 9, "R6 new period low", lo2, 9);

    // R7: bypass for 1 and for 0
    div_i = 8'd1;
    wait_halves(40);
    for (int k = 0; k < 8; k++) begin
      chk(clk_o === clk_i, "R7 bypass with 1", int'(clk_o), int'(clk_i));
      half();
    end
    div_i = 8'd0;
    wait_halves(4);
    for (int k = 0; k < 8; k++) begin
      chk(clk_o === clk_i, "R7 bypass with 0", int'(clk_o), int'(clk_i));
      half();
    end
    // R7: leaving bypass gives a clean divide by 4
    div_i = 8'd4;
    wait_halves(24);
    sync_rise();
    run(1'b1, hi);
    run(1'b0, lo);
    chk(hi == 4 && lo == 4, "R7 exit bypass high+low", hi + lo, 8);

    // R8: reset mid-run, then a full first period of 5
    div_i = 8'd5;
    wait_halves(40);
    rst_ni = 1'b0;
    for (int k = 0; k < 6; k++) begin
      half();
      chk(clk_o === 1'b0, "R8 low during reset", int'(clk_o), 0);
    end
    rst_ni = 1'b1;
    half();
    chk(clk_o === 1'b0, "R8 low during release sync", int'(clk_o), 0);
    sync_rise();
    run(1'b1, hi);
    run(1'b0, lo);
    chk(hi == 5, "R8 first high after release", hi, 5);
    chk(lo == 5, "R8 first low after release", lo, 5);

    finish_run();
  end
endmodule